// File: doc/BRIEF.md
# Sensorless Spindle Commutation Sequencer

This block steps a six-state commutation pointer for a three-phase brushless spindle motor that has no Hall sensors. Each state selects one half bridge to drive high, one to drive low and one to leave floating. After a run request it first spends a fixed window listening for a back-EMF zero crossing, so that a rotor that is still turning can be picked up without stopping it. If no crossing arrives, it pulls the rotor into a known position with a two-stage align sequence timed by a slow reference clock, then hands over to back-EMF driven stepping.

In steady running, each commutation is triggered by a go pulse from a separate delay block, which owns the phase-delay timing. A host can also step the pointer directly with a strobe, unless a lock input blocks that. A watchdog on the align reference clock holds the drivers off during start-up while that clock is absent, so the rotor is never left parked in one phase at full current.

Top module: `spin_seq`

## Requirements
- R1: While `run_i` is low, and after reset, `state_o` is 1 and `drv_en_o` is 0 from the next clock edge onward, with every leg at code 00.
- R2: While `oe_i` is low, `drv_en_o` is 0 and every leg of `drive_o` is 00 (floating), and the state still sequences as usual.
- R3: A rising edge on `run_i` moves the state to 2 with the drivers off, and keeps it there for a listening window of 2^CHECK_LOG system clocks.
- R4: A `zc_i` pulse during the listening window resynchronises: the state advances by one and the drivers come on in run mode.
- R5: If the window ends with no crossing and the align clock is present, the drivers come on in state 2. After ALIGN_A rising edges of the align clock the state advances by two, to 4.
- R6: After a further ALIGN_B align-clock rising edges, the block waits for a `zc_i` pulse, which advances the state by two. From then on, each `go_i` pulse advances it by one. `go_i` is ignored before that first crossing.
- R7: If no edge of the align clock arrives within WD_LIMIT system clocks, start-up stalls in state 2 with the drivers off. It restarts the align sequence from state 2 once the clock returns.
- R8: With `step_lock_i` low, a rising edge of `step_i` advances the state by one whenever `run_i` is high. An edge that comes fewer than MIN_GAP system clocks after the previously accepted one is ignored.
- R9: With `step_lock_i` high, edges on `step_i` have no effect on the state.
- R10: The state runs 1..6 and wraps 6 to 1. `drive_o` packs leg A in bits [1:0], B in [3:2] and C in [5:4], with code 10 for high, 01 for low and 00 for floating. The high/low pairs are: 1 A/B, 2 A/C, 3 B/C, 4 B/A, 5 C/A, 6 C/B.
- R11: `zc_i` pulses during the two align stages do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| run_i | input | 1 | Run request; low forces the idle state |
| oe_i | input | 1 | Output enable; low floats all legs |
| step_i | input | 1 | Host step strobe, acted on at its rising edge |
| step_lock_i | input | 1 | High blocks the host step strobe |
| align_clk_i | input | 1 | Slow align reference clock, asynchronous |
| zc_i | input | 1 | Qualified back-EMF zero-crossing pulse |
| go_i | input | 1 | Commutation pulse from the delay block |
| state_o | output | 3 | Commutation state 1..6 |
| drive_o | output | 6 | Per-leg drive codes, leg A in the low bits |
| drv_en_o | output | 1 | Power stage enable |

## Verification
The bench builds the block with CHECK_LOG=6, ALIGN_A=4, ALIGN_B=12, WD_LIMIT=32 and MIN_GAP=8, with the align clock toggling every four system clocks. These values shrink the 2^21-clock listening window and the 64/192 align stages to a few hundred cycles. That brings within reach the full path from idle through listening, both align stages, go mode and the wrap from 6 to 1, as well as a watchdog stall and its recovery. A short MIN_GAP lets both rejected and accepted host strobes be observed next to each other.

// File: rtl/spin_pkg.sv
package spin_pkg;

    typedef enum logic [2:0] {
        M_IDLE   = 3'd0,
        M_CHECK  = 3'd1,
        M_ALIGN1 = 3'd2,
        M_ALIGN2 = 3'd3,
        M_GO     = 3'd4,
        M_RUN    = 3'd5,
        M_STALL  = 3'd6
    } mode_e;

    localparam logic [1:0] DRV_OFF = 2'b00;
    localparam logic [1:0] DRV_LO  = 2'b01;
    localparam logic [1:0] DRV_HI  = 2'b10;

    function automatic logic [2:0] step_one(input logic [2:0] s);
        return (s == 3'd6) ? 3'd1 : s + 3'd1;
    endfunction

    function automatic logic [2:0] step_two(input logic [2:0] s);
        return (s >= 3'd5) ? s - 3'd4 : s + 3'd2;
    endfunction

    // leg index 0=A 1=B 2=C
    function automatic logic [1:0] high_leg(input logic [2:0] s);
        case (s)
            3'd1, 3'd2: return 2'd0;
            3'd3, 3'd4: return 2'd1;
            default:    return 2'd2;
        endcase
    endfunction

    function automatic logic [1:0] low_leg(input logic [2:0] s);
        case (s)
            3'd1, 3'd6: return 2'd1;
            3'd2, 3'd3: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spin_align_wd.sv
module spin_align_wd #(
    parameter int WD_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align_clk_i,
    output logic alive_o,
    output logic rise_o
);
    localparam int CW = $clog2(WD_LIMIT + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          prev;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t d, q;
    logic edge_seen;

    always_comb begin
        d         = q;
        edge_seen = q.sync[1] ^ q.prev;
        d.sync    = {q.sync[0], align_clk_i};
        d.prev    = q.sync[1];
        if (edge_seen)
            d.cnt = '0;
        else if (q.cnt != CW'(WD_LIMIT))
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '0;
            q.prev <= 1'b0;
            q.cnt  <= CW'(WD_LIMIT);
        end else begin
            q <= d;
        end
    end

    assign alive_o = (q.cnt != CW'(WD_LIMIT));
    assign rise_o  = q.sync[1] & ~q.prev;

endmodule

// File: rtl/spin_step_filter.sv
module spin_step_filter #(
    parameter int MIN_GAP = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic lock_i,
    output logic adv_o
);
    localparam int GW = $clog2(MIN_GAP + 1);

    typedef struct packed {
        logic          prev;
        logic [GW-1:0] gap;
    } flt_t;

    flt_t d, q;

    always_comb begin
        d      = q;
        d.prev = step_i;
        adv_o  = step_i & ~q.prev & ~lock_i & (q.gap == '0);
        if (adv_o)
            d.gap = GW'(MIN_GAP - 1);
        else if (q.gap != '0)
            d.gap = q.gap - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev <= 1'b0;
            q.gap  <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/spin_phase_map.sv
module spin_phase_map
    import spin_pkg::*;
(
    input  logic [2:0] phase_i,
    input  logic       en_i,
    output logic [5:0] drive_o
);
    logic [1:0] hi_leg, lo_leg;

    assign hi_leg = high_leg(phase_i);
    assign lo_leg = low_leg(phase_i);

    for (genvar p = 0; p < 3; p++) begin : g_leg
        always_comb begin
            if (!en_i)                drive_o[2*p +: 2] = DRV_OFF;
            else if (hi_leg == 2'(p)) drive_o[2*p +: 2] = DRV_HI;
            else if (lo_leg == 2'(p)) drive_o[2*p +: 2] = DRV_LO;
            else                      drive_o[2*p +: 2] = DRV_OFF;
        end
    end

endmodule

// File: rtl/spin_seq.sv
module spin_seq
    import spin_pkg::*;
#(
    parameter int CHECK_LOG = 21,
    parameter int ALIGN_A   = 64,
    parameter int ALIGN_B   = 192,
    parameter int WD_LIMIT  = 1024,
    parameter int MIN_GAP   = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       oe_i,
    input  logic       step_i,
    input  logic       step_lock_i,
    input  logic       align_clk_i,
    input  logic       zc_i,
    input  logic       go_i,
    output logic [2:0] state_o,
    output logic [5:0] drive_o,
    output logic       drv_en_o
);
    localparam int AMAX = (ALIGN_A > ALIGN_B) ? ALIGN_A : ALIGN_B;
    localparam int AW   = $clog2(AMAX + 1);

    typedef struct packed {
        mode_e                mode;
        logic [2:0]           phase;
        logic [CHECK_LOG-1:0] win;
        logic [AW-1:0]        aln;
        logic                 run_prev;
    } seq_t;

    seq_t d, q;
    logic align_alive, align_rise, host_adv;

    spin_align_wd #(.WD_LIMIT(WD_LIMIT)) i_wd (
        .clk         (clk),
        .rst_n       (rst_n),
        .align_clk_i (align_clk_i),
        .alive_o     (align_alive),
        .rise_o      (align_rise)
    );

    spin_step_filter #(.MIN_GAP(MIN_GAP)) i_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .lock_i (step_lock_i),
        .adv_o  (host_adv)
    );

    always_comb begin
        d          = q;
        d.run_prev = run_i;
        if (!run_i) begin
            d.mode  = M_IDLE;
            d.phase = 3'd1;
            d.win   = '0;
            d.aln   = '0;
        end else begin
            unique case (q.mode)
                M_IDLE: begin
                    if (!q.run_prev) begin
                        d.mode  = M_CHECK;
                        d.phase = 3'd2;
                        d.win   = '0;
                    end
                end
                M_CHECK: begin
                    if (zc_i) begin
                        d.mode  = M_RUN;
                        d.phase = step_one(q.phase);
                    end else if (&q.win) begin
                        d.mode = align_alive ? M_ALIGN1 : M_STALL;
                        d.aln  = '0;
                    end else begin
                        d.win = q.win + 1'b1;
                    end
                end
                M_ALIGN1: begin
                    if (!align_alive) begin
                        d.mode = M_STALL;
                    end else if (align_rise) begin
                        if (q.aln == AW'(ALIGN_A - 1)) begin
                            d.mode  = M_ALIGN2;
                            d.phase = step_two(q.phase);
                            d.aln   = '0;
                        end else begin
                            d.aln = q.aln + 1'b1;
                        end
                    end
                end
                M_ALIGN2: begin
                    if (!align_alive) begin
                        d.mode = M_STALL;
                    end else if (align_rise) begin
                        if (q.aln == AW'(ALIGN_B - 1)) begin
                            d.mode = M_GO;
                            d.aln  = '0;
                        end else begin
                            d.aln = q.aln + 1'b1;
                        end
                    end
                end
                M_GO: begin
                    if (zc_i) begin
                        d.mode  = M_RUN;
                        d.phase = step_two(q.phase);
                    end
                end
                M_RUN: begin
                    if (go_i) d.phase = step_one(q.phase);
                end
                M_STALL: begin
                    d.phase = 3'd2;
                    if (align_alive) begin
                        d.mode = M_ALIGN1;
                        d.aln  = '0;
                    end
                end
                default: d.mode = M_IDLE;
            endcase
            if (host_adv) d.phase = step_one(q.phase);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode     <= M_IDLE;
            q.phase    <= 3'd1;
            q.win      <= '0;
            q.aln      <= '0;
            q.run_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o  = q.phase;
    assign drv_en_o = oe_i && (q.mode == M_ALIGN1 || q.mode == M_ALIGN2 ||
                               q.mode == M_GO     || q.mode == M_RUN);

    spin_phase_map i_map (
        .phase_i (q.phase),
        .en_i    (drv_en_o),
        .drive_o (drive_o)
    );

endmodule

// File: rtl/spin_seq_chk.sv
module spin_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_i,
    input logic       oe_i,
    input logic [2:0] state_o,
    input logic [5:0] drive_o,
    input logic       drv_en_o
);
    function automatic int legs_with(input logic [5:0] v, input logic [1:0] c);
        int n = 0;
        for (int i = 0; i < 3; i++) if (v[2*i +: 2] == c) n++;
        return n;
    endfunction

    AST_RUN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_o == 3'd1) && !drv_en_o) else $error("run low"); // R1

    AST_OE_LOW_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> (drive_o == 6'b0) && !drv_en_o) else $error("oe low"); // R2

    AST_LISTEN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |=> !drv_en_o && (state_o == 3'd2)) else $error("listen"); // R3

    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o >= 3'd1) && (state_o <= 3'd6)) else $error("range"); // R10

    AST_ONE_HI_ONE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> (legs_with(drive_o, 2'b10) == 1) && (legs_with(drive_o, 2'b01) == 1))
        else $error("legs"); // R10

    AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && (state_o != $past(state_o))) |->
        ((state_o == (($past(state_o) == 3'd6) ? 3'd1 : $past(state_o) + 3'd1)) ||
         (state_o == (($past(state_o) >= 3'd5) ? $past(state_o) - 3'd4 : $past(state_o) + 3'd2)) ||
         (state_o == 3'd2))) else $error("step"); // R10

endmodule

bind spin_seq spin_seq_chk i_spin_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .oe_i     (oe_i),
    .state_o  (state_o),
    .drive_o  (drive_o),
    .drv_en_o (drv_en_o)
);

// File: tb/test_spin_seq.sv
module test_spin_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0, oe_i = 1'b1, step_i = 1'b0, step_lock_i = 1'b0;
    logic       align_clk_i = 1'b0, zc_i = 1'b0, go_i = 1'b0;
    logic       aln_en = 1'b1;
    logic [2:0] state_o;
    logic [5:0] drive_o;
    logic       drv_en_o;
    int         vectors = 0, miscompares = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    always begin
        repeat (4) @(negedge clk);
        if (aln_en) align_clk_i = ~align_clk_i;
    end

    spin_seq #(.CHECK_LOG(6), .ALIGN_A(4), .ALIGN_B(12), .WD_LIMIT(32), .MIN_GAP(8)) i_spin_seq (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .oe_i(oe_i), .step_i(step_i),
        .step_lock_i(step_lock_i), .align_clk_i(align_clk_i), .zc_i(zc_i), .go_i(go_i),
        .state_o(state_o), .drive_o(drive_o), .drv_en_o(drv_en_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_zc();  zc_i = 1'b1;   tick(1); zc_i = 1'b0;   endtask
    task automatic pulse_go();  go_i = 1'b1;   tick(1); go_i = 1'b0;   endtask
    task automatic pulse_stp(); step_i = 1'b1; tick(1); step_i = 1'b0; endtask

    task automatic t_reset();
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R1 state", state_o, 1);
        chk("R1 drv_en", drv_en_o, 0);
        chk("R1 drive", drive_o, 0);
    endtask

    task automatic t_startup();
        run_i = 1'b1;
        tick(20);
        chk("R3 state", state_o, 2);
        chk("R3 drv_en", drv_en_o, 0);
        tick(55);
        pulse_zc();
        tick(4);
        chk("R11 state", state_o, 2);
        chk("R5 drv_en", drv_en_o, 1);
        chk("R10 drive s2", drive_o, 6'b010010);
        tick(50);
        chk("R5 state", state_o, 4);
        tick(90);
        chk("R6 state go", state_o, 4);
        pulse_go();
        chk("R6 go ignored", state_o, 4);
        pulse_zc();
        chk("R6 zc step", state_o, 6);
        pulse_go();
        chk("R10 wrap", state_o, 1);
        chk("R10 drive s1", drive_o, 6'b000110);
        pulse_go();
        chk("R6 go step", state_o, 2);
    endtask

    task automatic t_resync();
        run_i = 1'b0;
        tick(2);
        chk("R1 run low", state_o, 1);
        chk("R1 run low drv", drv_en_o, 0);
        run_i = 1'b1;
        tick(10);
        pulse_zc();
        chk("R4 state", state_o, 3);
        chk("R4 drv_en", drv_en_o, 1);
    endtask

    task automatic t_strobe();
        pulse_stp();
        chk("R8 accept", state_o, 4);
        tick(2);
        pulse_stp();
        chk("R8 too close", state_o, 4);
        tick(10);
        pulse_stp();
        chk("R8 accept again", state_o, 5);
        step_lock_i = 1'b1;
        tick(10);
        pulse_stp();
        tick(1);
        chk("R9 locked", state_o, 5);
        step_lock_i = 1'b0;
    endtask

    task automatic t_oe();
        oe_i = 1'b0;
        tick(1);
        chk("R2 drive", drive_o, 0);
        chk("R2 drv_en", drv_en_o, 0);
        pulse_go();
        chk("R2 sequencing", state_o, 6);
        oe_i = 1'b1;
        tick(1);
        chk("R10 drive s6", drive_o, 6'b100100);
    endtask

    task automatic t_watchdog();
        run_i = 1'b0;
        aln_en = 1'b0;
        tick(50);
        run_i = 1'b1;
        tick(100);
        chk("R7 stall state", state_o, 2);
        chk("R7 stall drv", drv_en_o, 0);
        aln_en = 1'b1;
        tick(20);
        chk("R7 resume drv", drv_en_o, 1);
        chk("R7 resume state", state_o, 2);
        tick(200);
        chk("R7 reach go", state_o, 4);
        pulse_zc();
        chk("R7 go zc", state_o, 6);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_resync();
        t_strobe();
        t_oe();
        t_watchdog();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule